// File: doc/BRIEF.md
# DMA Handshake Sequencer

This block drives the byte-wide side of a bidirectional buffer as a bus master when that side is in peripheral mode. When a transfer is pending it raises a request, waits a programmed number of internal clocks, then raises the acknowledge and pulses the data strobes for one or two internal clocks. After that it drops everything and returns to idle. The strobes come in two styles: two separate active-low read and write strobes, or one active-low data strobe with a read/write select line.

All timing is counted in internal clocks. An internal clock is either every CLK edge or every other CLK edge. The slow rate is a clock enable, so everything stays in one clock domain. The polarity of the request and of the acknowledge can each be set. In processor mode the strobe pins belong to an outside master. The sequencer then releases their output enable, drives request and acknowledge low, and stays idle. The direction of the most recent transfer is reported for a status word. Data movement and buffer flags belong elsewhere.

Top module: `dma_hs_seq`

## Requirements
- R1: After synchronous reset, with active-high polarities, req_o and ack_o are 0, strb_a_o and strb_b_o are 1, and dir_stat_o is 0.
- R2: When xfer_pend_i is seen in idle in peripheral mode, the request is asserted. The acknowledge follows cfg_gap_i+2 internal clocks later (00 gives 2, 01 gives 3, 10 gives 4, 11 gives 5).
- R3: The strobe starts in the same internal clock as the acknowledge. It lasts 1 internal clock when cfg_wide_i=0 and 2 when cfg_wide_i=1.
- R4: Request and acknowledge deassert together with the end of the strobe. The request is active for gap plus strobe internal clocks in total.
- R5: With cfg_div2_i=1 an internal clock is two CLK cycles, so every duration in R2 to R4 doubles in CLK cycles.
- R6: cfg_req_pol_i=1 makes req_o active high and 0 makes it active low. cfg_ack_pol_i does the same for ack_o. The inactive level is the inverse of the active level.
- R7: With cfg_moto_i=0, strb_a_o is an active-low read strobe (xfer_rd_i=1) and strb_b_o is an active-low write strobe (xfer_rd_i=0). Both are 1 when idle.
- R8: With cfg_moto_i=1, strb_a_o is an active-low data strobe. During the strobe, strb_b_o is the read/write select, 1 for read and 0 for write. When idle, strb_b_o is 1.
- R9: With cfg_periph_i=0, strb_oe_o is 0 and req_o and ack_o are 0 whatever the polarities. A pending transfer is ignored.
- R10: Clearing cfg_periph_i mid-sequence aborts it at once. When peripheral mode returns, the sequencer stays idle until xfer_pend_i is seen.
- R11: dir_stat_o takes xfer_rd_i when a request starts and holds it until the next request starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_pend_i | input | 1 | A transfer is waiting |
| xfer_rd_i | input | 1 | Direction of the transfer, 1 = read |
| cfg_div2_i | input | 1 | Internal clock is CLK/2 when 1 |
| cfg_gap_i | input | GAP_W | Request-to-acknowledge gap code |
| cfg_wide_i | input | 1 | Two-clock strobe when 1 |
| cfg_req_pol_i | input | 1 | Active level of req_o |
| cfg_ack_pol_i | input | 1 | Active level of ack_o |
| cfg_moto_i | input | 1 | Data strobe plus read/write select when 1 |
| cfg_periph_i | input | 1 | Peripheral (master) mode when 1 |
| req_o | output | 1 | DMA request |
| ack_o | output | 1 | DMA acknowledge |
| strb_a_o | output | 1 | Read strobe, or data strobe |
| strb_b_o | output | 1 | Write strobe, or read/write select |
| strb_oe_o | output | 1 | Output enable for the strobe pins |
| dir_stat_o | output | 1 | Direction of the latest transfer |

## Verification
The hardest case to reach is an abort that lands inside the request-to-acknowledge gap, together with the proof that no stale sequence resumes when peripheral mode comes back. The bench waits until the request is seen active at the pins. It then clears peripheral mode two cycles into a five-clock gap and checks that every pin goes inactive at once. It brings peripheral mode back with nothing pending and watches the request stay quiet. The divide-by-two cases start at whatever tick phase the bench happens to meet, so durations are measured from edges rather than from absolute cycles.

// File: rtl/dma_seq_pkg.sv
`timescale 1ns/1ps
package dma_seq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_WAIT   = 2'd1,
        SQ_STROBE = 2'd2
    } sq_state_e;

    // settings captured when a request starts
    typedef struct packed {
        logic rd;
        logic wide;
        logic moto;
    } xfer_cfg_t;

    // abstract sequencer outputs, before polarity and style are applied
    typedef struct packed {
        logic req;
        logic ack;
        logic strobe;
    } seq_out_t;

    // strobe length in internal clocks, minus one
    function automatic logic strobe_last(input logic wide);
        return wide;
    endfunction

endpackage

// File: rtl/dma_tick_gen.sv
`timescale 1ns/1ps
module dma_tick_gen (
    input  logic clk,
    input  logic rst,
    input  logic div2,
    output logic tick_o
);
    logic ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= 1'b0;
        end else if (div2) begin
            ph_q <= ~ph_q;
        end else begin
            ph_q <= 1'b0;
        end
    end

    assign tick_o = ~div2 | ph_q;
endmodule

// File: rtl/dma_seq_fsm.sv
`timescale 1ns/1ps
module dma_seq_fsm
    import dma_seq_pkg::*;
#(
    parameter int GAP_W   = 2,
    parameter int MIN_GAP = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             enable,
    input  logic             pend,
    input  logic             rd,
    input  logic [GAP_W-1:0] gap,
    input  logic             wide,
    input  logic             moto,
    output seq_out_t         seq_o,
    output xfer_cfg_t        cfg_o
);
    localparam int MAX_GAP = MIN_GAP + (1 << GAP_W) - 1;
    localparam int CNT_W   = $clog2(MAX_GAP + 1);

    sq_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    xfer_cfg_t        cfg_q;
    logic [GAP_W-1:0] gap_q;
    logic [CNT_W-1:0] gap_last;
    logic [CNT_W-1:0] str_last;

    assign gap_last = CNT_W'(MIN_GAP) + CNT_W'(gap_q) - CNT_W'(1);
    assign str_last = CNT_W'(strobe_last(cfg_q.wide));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            cfg_q   <= '0;
            gap_q   <= '0;
        end else if (!enable) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
        end else if (tick) begin
            case (state_q)
                SQ_IDLE: begin
                    if (pend) begin
                        state_q <= SQ_WAIT;
                        cnt_q   <= '0;
                        cfg_q   <= '{rd: rd, wide: wide, moto: moto};
                        gap_q   <= gap;
                    end
                end
                SQ_WAIT: begin
                    if (cnt_q == gap_last) begin
                        state_q <= SQ_STROBE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                SQ_STROBE: begin
                    if (cnt_q == str_last) begin
                        state_q <= SQ_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: begin
                    state_q <= SQ_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    always_comb begin
        seq_o.req    = (state_q != SQ_IDLE);
        seq_o.ack    = (state_q == SQ_STROBE);
        seq_o.strobe = (state_q == SQ_STROBE);
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/dma_pin_drive.sv
`timescale 1ns/1ps
module dma_pin_drive
    import dma_seq_pkg::*;
(
    input  seq_out_t seq_i,
    input  logic     enable,
    input  logic     rd,
    input  logic     moto,
    input  logic     req_pol,
    input  logic     ack_pol,
    output logic     req_o,
    output logic     ack_o,
    output logic     pin_a_o,
    output logic     pin_b_o,
    output logic     oe_o
);
    always_comb begin
        req_o   = 1'b0;
        ack_o   = 1'b0;
        pin_a_o = 1'b1;
        pin_b_o = 1'b1;
        oe_o    = 1'b0;
        if (enable) begin
            oe_o  = 1'b1;
            req_o = seq_i.req ? req_pol : ~req_pol;
            ack_o = seq_i.ack ? ack_pol : ~ack_pol;
            if (seq_i.strobe) begin
                if (moto) begin
                    pin_a_o = 1'b0;
                    pin_b_o = rd;
                end else begin
                    pin_a_o = ~rd;
                    pin_b_o = rd;
                end
            end
        end
    end
endmodule

// File: rtl/dma_hs_seq.sv
`timescale 1ns/1ps
module dma_hs_seq
    import dma_seq_pkg::*;
#(
    parameter int GAP_W   = 2,
    parameter int MIN_GAP = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xfer_pend_i,
    input  logic             xfer_rd_i,
    input  logic             cfg_div2_i,
    input  logic [GAP_W-1:0] cfg_gap_i,
    input  logic             cfg_wide_i,
    input  logic             cfg_req_pol_i,
    input  logic             cfg_ack_pol_i,
    input  logic             cfg_moto_i,
    input  logic             cfg_periph_i,
    output logic             req_o,
    output logic             ack_o,
    output logic             strb_a_o,
    output logic             strb_b_o,
    output logic             strb_oe_o,
    output logic             dir_stat_o
);
    logic      tick;
    seq_out_t  seq;
    xfer_cfg_t cur_cfg;

    dma_tick_gen u_tick (
        .clk    (clk),
        .rst    (rst),
        .div2   (cfg_div2_i),
        .tick_o (tick)
    );

    dma_seq_fsm #(
        .GAP_W   (GAP_W),
        .MIN_GAP (MIN_GAP)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .enable (cfg_periph_i),
        .pend   (xfer_pend_i),
        .rd     (xfer_rd_i),
        .gap    (cfg_gap_i),
        .wide   (cfg_wide_i),
        .moto   (cfg_moto_i),
        .seq_o  (seq),
        .cfg_o  (cur_cfg)
    );

    dma_pin_drive u_pins (
        .seq_i   (seq),
        .enable  (cfg_periph_i),
        .rd      (cur_cfg.rd),
        .moto    (cur_cfg.moto),
        .req_pol (cfg_req_pol_i),
        .ack_pol (cfg_ack_pol_i),
        .req_o   (req_o),
        .ack_o   (ack_o),
        .pin_a_o (strb_a_o),
        .pin_b_o (strb_b_o),
        .oe_o    (strb_oe_o)
    );

    assign dir_stat_o = cur_cfg.rd;
endmodule

// File: rtl/dma_hs_seq_chk.sv
`timescale 1ns/1ps
module dma_hs_seq_chk (
    input logic clk,
    input logic rst,
    input logic cfg_div2_i,
    input logic cfg_req_pol_i,
    input logic cfg_ack_pol_i,
    input logic cfg_moto_i,
    input logic cfg_periph_i,
    input logic req_o,
    input logic ack_o,
    input logic strb_a_o,
    input logic strb_b_o,
    input logic strb_oe_o,
    input logic dir_stat_o
);
    logic req_act;
    logic ack_act;
    logic strb_act;

    assign req_act  = cfg_periph_i && (req_o == cfg_req_pol_i);
    assign ack_act  = cfg_periph_i && (ack_o == cfg_ack_pol_i);
    assign strb_act = strb_oe_o && (!strb_a_o || (!cfg_moto_i && !strb_b_o));

    // R4
    ack_in_req_chk: assert property (@(posedge clk) disable iff (rst)
        ack_act |-> req_act);

    // R3
    strobe_in_ack_chk: assert property (@(posedge clk) disable iff (rst)
        strb_act |-> ack_act);

    // R2
    req_before_ack_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_act) |-> $past(req_act));

    // R9
    proc_mode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_periph_i |-> (!strb_oe_o && !req_o && !ack_o));

    // R10
    resume_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_periph_i && $past(!cfg_periph_i)) |-> !req_act);

    // R11
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_act && $past(req_act)) |-> $stable(dir_stat_o));

    // R5
    slow_req_len_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_div2_i && $past(cfg_div2_i) && $rose(req_act)) |=> req_act);
endmodule

bind dma_hs_seq dma_hs_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_div2_i    (cfg_div2_i),
    .cfg_req_pol_i (cfg_req_pol_i),
    .cfg_ack_pol_i (cfg_ack_pol_i),
    .cfg_moto_i    (cfg_moto_i),
    .cfg_periph_i  (cfg_periph_i),
    .req_o         (req_o),
    .ack_o         (ack_o),
    .strb_a_o      (strb_a_o),
    .strb_b_o      (strb_b_o),
    .strb_oe_o     (strb_oe_o),
    .dir_stat_o    (dir_stat_o)
);

// File: tb/test_dma_hs_seq.sv
`timescale 1ns/1ps
module test_dma_hs_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pend = 1'b0, rd = 1'b0, div2 = 1'b0, wide = 1'b0;
    logic [1:0] gap = 2'd0;
    logic       rpol = 1'b1, apol = 1'b1, moto = 1'b0, periph = 1'b1;
    logic       req_o, ack_o, sa, sb, soe, dstat;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    dma_hs_seq i_dma_hs_seq (
        .clk(clk), .rst(rst), .xfer_pend_i(pend), .xfer_rd_i(rd),
        .cfg_div2_i(div2), .cfg_gap_i(gap), .cfg_wide_i(wide),
        .cfg_req_pol_i(rpol), .cfg_ack_pol_i(apol), .cfg_moto_i(moto),
        .cfg_periph_i(periph), .req_o(req_o), .ack_o(ack_o),
        .strb_a_o(sa), .strb_b_o(sb), .strb_oe_o(soe), .dir_stat_o(dstat)
    );

    // {div2, gap[1:0], wide, rpol, apol, moto, rd, exp_gap[3:0], exp_strobe[3:0]}
    // expected values are in CLK cycles
    localparam int NV = 8;
    localparam logic [15:0] VEC [NV] = '{
        16'b0_00_0_1_1_0_1_0010_0001,
        16'b0_01_1_1_0_0_0_0011_0010,
        16'b0_10_0_0_1_1_1_0100_0001,
        16'b0_11_1_0_0_1_0_0101_0010,
        16'b1_00_0_1_1_0_0_0100_0010,
        16'b1_11_1_1_1_1_1_1010_0100,
        16'b1_01_0_0_0_0_1_0110_0010,
        16'b1_10_1_0_1_1_0_1000_0100
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_xfer(input logic [15:0] v);
        int first_req, first_ack, nreq, nack, nstr, bad_pat;
        logic sact;
        {div2, gap, wide, rpol, apol, moto, rd} = v[15:8];
        first_req = -1; first_ack = -1;
        nreq = 0; nack = 0; nstr = 0; bad_pat = 0;
        @(negedge clk);
        pend = 1'b1;
        for (int c = 0; c < 120; c++) begin
            @(negedge clk);
            if (req_o == rpol) begin
                nreq++;
                if (first_req < 0) first_req = c;
                pend = 1'b0;
            end
            if (ack_o == apol) begin
                nack++;
                if (first_ack < 0) first_ack = c;
            end
            sact = moto ? !sa : (!sa || !sb);
            if (sact) begin
                nstr++;
                if (moto) begin
                    if (sb != rd) bad_pat++;
                end else if (rd ? !(sa == 1'b0 && sb == 1'b1) : !(sa == 1'b1 && sb == 1'b0)) begin
                    bad_pat++;
                end
            end
        end
        // R2 R5: gap from request to acknowledge
        chk((first_ack - first_req) == int'(v[7:4]), "R2/R5 gap", first_ack - first_req, int'(v[7:4]));
        // R3: strobe length, and the acknowledge covers the same span
        chk(nstr == int'(v[3:0]), "R3 strobe len", nstr, int'(v[3:0]));
        chk(nack == int'(v[3:0]), "R3 ack len", nack, int'(v[3:0]));
        // R4: request length
        chk(nreq == int'(v[7:4]) + int'(v[3:0]), "R4 req len", nreq, int'(v[7:4]) + int'(v[3:0]));
        // R7 R8: strobe pin pattern
        chk(bad_pat == 0, moto ? "R8 strobe pattern" : "R7 strobe pattern", bad_pat, 0);
        // R6: inactive levels once idle
        chk(req_o == !rpol && ack_o == !apol, "R6 idle levels", {req_o, ack_o}, {!rpol, !apol});
        chk(sa && sb, "R7 idle strobes", {sa, sb}, 3);
        // R11
        chk(dstat == rd, "R11 dir status", dstat, rd);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int bad, seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(req_o == 0 && ack_o == 0, "R1 reset req/ack", {req_o, ack_o}, 0);
        chk(sa && sb && soe, "R1 reset strobes", {sa, sb, soe}, 7);
        chk(dstat == 0, "R1 reset dir", dstat, 0);

        for (int i = 0; i < NV; i++) run_xfer(VEC[i]);

        // R9: processor mode ignores a pending transfer and polarity
        periph = 1'b0; rpol = 1'b0; apol = 1'b0; div2 = 1'b0;
        pend = 1'b1; bad = 0;
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (req_o !== 1'b0 || ack_o !== 1'b0 || soe !== 1'b0) bad++;
        end
        pend = 1'b0;
        chk(bad == 0, "R9 processor mode quiet", bad, 0);

        // R10: abort inside a 5-clock gap
        rpol = 1'b1; apol = 1'b1; gap = 2'd3; wide = 1'b0; moto = 1'b0; rd = 1'b1;
        periph = 1'b1;
        @(negedge clk);
        pend = 1'b1;
        seen = 0;
        for (int c = 0; c < 20 && seen == 0; c++) begin
            @(negedge clk);
            if (req_o == 1'b1) seen = 1;
        end
        pend = 1'b0;
        chk(seen == 1, "R2 req before abort", seen, 1);
        repeat (2) @(negedge clk);
        chk(ack_o == 1'b0, "R10 still in gap", ack_o, 0);
        periph = 1'b0;
        @(negedge clk);
        chk(req_o == 0 && ack_o == 0 && soe == 0 && sa && sb, "R10 abort outputs",
            {req_o, ack_o, soe, sa, sb}, 3);
        periph = 1'b1;
        bad = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (req_o != 1'b0 || ack_o != 1'b0) bad++;
        end
        chk(bad == 0, "R10 resume idle", bad, 0);
        pend = 1'b1;
        seen = 0;
        for (int c = 0; c < 5 && seen == 0; c++) begin
            @(negedge clk);
            if (req_o == 1'b1) seen = 1;
        end
        pend = 1'b0;
        chk(seen == 1, "R10 restart after resume", seen, 1);
        repeat (20) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule